// File: doc/BRIEF.md
# Hardened Ping Timer

The ping timer checks that a set of alert senders and escalation receivers are still alive. At pseudo-random moments it picks one of them, raises a ping request on that line and waits for an acknowledge. If no acknowledge arrives before a programmable timeout, it pulses a fail alert for that target. Both the gap between pings and the choice of target come from an LFSR. The LFSR is seeded from an entropy source through a request/acknowledge handshake, once after reset and again after a fixed number of pings.

The block is built to withstand fault injection. The control state machine uses a sparse state code, so no single flipped bit turns one legal state into another. The LFSR and the wait/timeout counter each exist as two copies that run in lockstep and are compared on every cycle. An illegal state code, or any difference between the copies, sends the controller into a terminal error state. In that state every fail alert stays high until reset.

Top module: `ping_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, `ent_req_o` is 1 and `ping_req_o` and `fail_o` are all zero.
- R2: `ent_req_o` stays high until `ent_ack_i` is sampled high. At that edge the LFSR is loaded with `ent_data_i`, or with 1 if that value is zero. No ping is issued before the first such load.
- R3: The LFSR is a right-shifting Galois register with feedback mask 0xB400 (16 bits). It advances exactly once at the end of each ping and does not change at any other time.
- R4: The ping target is bits [15:8] of the LFSR, taken modulo N_TARGETS. At most one `ping_req_o` bit is high at a time, and it stays high until the ping ends.
- R5: After a ping ends, the block spends one idle cycle. It then waits MIN_WAIT + LFSR[3:0] + 1 cycles (MIN_WAIT defaults to 2), using the already advanced LFSR value, and then raises the next request.
- R6: A high `ping_ack_i` bit on the target line ends the ping in that cycle with no fail alert. Acknowledges on other lines, or outside a ping, are ignored.
- R7: The counter is 0 in the first request cycle and counts up each cycle. If the target is not acknowledged by the cycle in which the counter is at least `timeout_i`, the ping ends. The target's `fail_o` bit is then high for exactly the next cycle.
- R8: While `en_i` is low, no new wait or ping starts. Dropping `en_i` during a wait returns the block to idle. A ping already in progress runs to its end.
- R9: After every RESEED_PINGS completed pings (default 4), the block raises `ent_req_o` again. It issues no ping until that handshake completes.
- R10: If the two LFSR copies or the two counter copies differ, or the state code is illegal, then from the next cycle on all `fail_o` bits are 1 and `ping_req_o` and `ent_req_o` are 0, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows ping rounds to start |
| timeout_i | input | CNT_W | Counter value at which an unanswered ping fails |
| ent_req_o | output | 1 | Entropy request for a reseed |
| ent_ack_i | input | 1 | Entropy acknowledge; `ent_data_i` is valid with it |
| ent_data_i | input | LFSR_W | Fresh seed value |
| ping_ack_i | input | N_TARGETS | Per-target ping acknowledge |
| ping_req_o | output | N_TARGETS | Per-target ping request, at most one high |
| fail_o | output | N_TARGETS | Per-target ping-fail alert |

## Verification
A wrong LFSR value shows at the ports as a different target or a shifted request time on the next ping. A wrong counter value shows as a request that ends, or a fail pulse that appears, one or more cycles away from the expected cycle. The bench therefore compares `ping_req_o`, `fail_o` and `ent_req_o` against a behavioural model on every cycle, so such a fault is seen within one ping round. A disagreement forced between the duplicated copies must turn every fail alert on in the very next cycle, and the alerts must stay on.

// File: rtl/ping_pkg.sv
package ping_pkg;

  localparam int unsigned ST_W = 6;

  // Sparse state code: every pair of legal codes differs in at least two bits.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 6'b110000,
    ST_RESEED = 6'b011100,
    ST_WAIT   = 6'b000111,
    ST_PING   = 6'b101011,
    ST_ERROR  = 6'b111111
  } ping_st_e;

endpackage

// File: rtl/ping_lfsr.sv
module ping_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] INIT = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  function automatic logic [W-1:0] galois_step(input logic [W-1:0] v);
    return (v >> 1) ^ (v[0] ? TAPS : '0);
  endfunction

  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= INIT;
    end else if (load_i) begin
      val_q <= seed_i;
    end else if (adv_i) begin
      val_q <= galois_step(val_q);
    end
  end

  assign state_o = val_q;

endmodule

// File: rtl/ping_cnt.sv
module ping_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/ping_fsm.sv
module ping_fsm
  import ping_pkg::*;
#(
  parameter int unsigned RESEED_PINGS = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     ent_ack_i,
  input  logic     wait_hit_i,
  input  logic     ack_hit_i,
  input  logic     timed_out_i,
  input  logic     fault_i,
  output ping_st_e state_o,
  output logic     in_reseed_o,
  output logic     in_ping_o,
  output logic     is_err_o,
  output logic     cnt_clr_o,
  output logic     cnt_inc_o,
  output logic     seed_load_o,
  output logic     lfsr_adv_o,
  output logic     timeout_evt_o
);

  localparam int unsigned PC_W = $clog2(RESEED_PINGS + 1);
  localparam logic [PC_W-1:0] LAST_PING = PC_W'(RESEED_PINGS - 1);

  ping_st_e        state_q, state_d;
  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic            illegal;

  always_comb begin
    state_d       = state_q;
    pcnt_d        = pcnt_q;
    illegal       = 1'b0;
    cnt_clr_o     = 1'b1;
    cnt_inc_o     = 1'b0;
    seed_load_o   = 1'b0;
    lfsr_adv_o    = 1'b0;
    timeout_evt_o = 1'b0;
    case (state_q)
      ST_RESEED: begin
        if (ent_ack_i) begin
          seed_load_o = 1'b1;
          pcnt_d      = '0;
          state_d     = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (en_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!en_i) begin
          state_d = ST_IDLE;
        end else if (wait_hit_i) begin
          state_d = ST_PING;
        end else begin
          cnt_clr_o = 1'b0;
          cnt_inc_o = 1'b1;
        end
      end
      ST_PING: begin
        if (ack_hit_i || timed_out_i) begin
          timeout_evt_o = !ack_hit_i;
          lfsr_adv_o    = 1'b1;
          if (pcnt_q == LAST_PING) begin
            state_d = ST_RESEED;
          end else begin
            pcnt_d  = pcnt_q + PC_W'(1);
            state_d = ST_IDLE;
          end
        end else begin
          cnt_clr_o = 1'b0;
          cnt_inc_o = 1'b1;
        end
      end
      ST_ERROR: ;
      default: illegal = 1'b1;
    endcase
    if (fault_i || illegal) begin
      state_d       = ST_ERROR;
      seed_load_o   = 1'b0;
      lfsr_adv_o    = 1'b0;
      timeout_evt_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESEED;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign state_o     = state_q;
  assign in_reseed_o = (state_q == ST_RESEED);
  assign in_ping_o   = (state_q == ST_PING);
  assign is_err_o    = (state_q == ST_ERROR);

endmodule

// File: rtl/ping_timer.sv
module ping_timer
  import ping_pkg::*;
#(
  parameter int unsigned  N_TARGETS    = 6,
  parameter int unsigned  LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int unsigned  CNT_W        = 16,
  parameter int unsigned  WAIT_BITS    = 4,
  parameter int unsigned  MIN_WAIT     = 2,
  parameter int unsigned  SEL_BITS     = 8,
  parameter int unsigned  RESEED_PINGS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [CNT_W-1:0]     timeout_i,
  output logic                 ent_req_o,
  input  logic                 ent_ack_i,
  input  logic [LFSR_W-1:0]    ent_data_i,
  input  logic [N_TARGETS-1:0] ping_ack_i,
  output logic [N_TARGETS-1:0] ping_req_o,
  output logic [N_TARGETS-1:0] fail_o
);

  localparam int unsigned TGT_W = (N_TARGETS > 1) ? $clog2(N_TARGETS) : 1;

  // Target index: upper SEL_BITS of the LFSR folded onto the target range.
  function automatic logic [TGT_W-1:0] pick_target(input logic [LFSR_W-1:0] v);
    logic [SEL_BITS-1:0] sel;
    sel = v[LFSR_W-1 -: SEL_BITS];
    return TGT_W'(32'(sel) % N_TARGETS);
  endfunction

  // Waiting span: fixed floor plus low LFSR bits.
  function automatic logic [CNT_W-1:0] wait_span(input logic [LFSR_W-1:0] v);
    return CNT_W'(MIN_WAIT) + CNT_W'(v[WAIT_BITS-1:0]);
  endfunction

  logic [LFSR_W-1:0]    lfsr_a, lfsr_b, seed;
  logic [CNT_W-1:0]     cnt_a, cnt_b;
  logic [TGT_W-1:0]     tgt;
  logic                 dup_mismatch, wait_hit, ack_hit, timed_out;
  logic                 in_reseed, in_ping, is_err;
  logic                 cnt_clr, cnt_inc, seed_load, lfsr_adv, timeout_evt;
  logic [N_TARGETS-1:0] fail_q, fail_d;
  ping_st_e             state;

  assign seed = (ent_data_i == '0) ? LFSR_W'(1) : ent_data_i;

  ping_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(seed_load), .seed_i(seed),
    .adv_i(lfsr_adv), .state_o(lfsr_a)
  );

  ping_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(seed_load), .seed_i(seed),
    .adv_i(lfsr_adv), .state_o(lfsr_b)
  );

  ping_cnt #(.W(CNT_W)) u_cnt_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc), .count_o(cnt_a)
  );

  ping_cnt #(.W(CNT_W)) u_cnt_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .inc_i(cnt_inc), .count_o(cnt_b)
  );

  assign dup_mismatch = (lfsr_a != lfsr_b) || (cnt_a != cnt_b);
  assign tgt          = pick_target(lfsr_a);
  assign wait_hit     = (cnt_a == wait_span(lfsr_a));
  assign ack_hit      = ping_ack_i[tgt];
  assign timed_out    = (cnt_a >= timeout_i);

  ping_fsm #(.RESEED_PINGS(RESEED_PINGS)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ent_ack_i(ent_ack_i),
    .wait_hit_i(wait_hit), .ack_hit_i(ack_hit), .timed_out_i(timed_out),
    .fault_i(dup_mismatch), .state_o(state), .in_reseed_o(in_reseed),
    .in_ping_o(in_ping), .is_err_o(is_err), .cnt_clr_o(cnt_clr),
    .cnt_inc_o(cnt_inc), .seed_load_o(seed_load), .lfsr_adv_o(lfsr_adv),
    .timeout_evt_o(timeout_evt)
  );

  for (genvar i = 0; i < N_TARGETS; i++) begin : g_tgt
    assign ping_req_o[i] = in_ping && (tgt == TGT_W'(i));
    assign fail_d[i]     = timeout_evt && (tgt == TGT_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= '0;
    else         fail_q <= fail_d;
  end

  assign fail_o    = fail_q | {N_TARGETS{is_err}};
  assign ent_req_o = in_reseed;

endmodule

// File: rtl/ping_timer_chk.sv
module ping_timer_chk #(
  parameter int unsigned N_TARGETS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ent_req_o,
  input logic                 ent_ack_i,
  input logic [N_TARGETS-1:0] ping_req_o,
  input logic [N_TARGETS-1:0] ping_ack_i,
  input logic [N_TARGETS-1:0] fail_o,
  input logic                 is_err,
  input logic                 dup_mismatch,
  input logic                 timeout_evt
);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_err |=> is_err);

  // R10
  mismatch_alarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_mismatch |=> (fail_o == '1) && (ping_req_o == '0) && !ent_req_o);

  // R4
  single_ping_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ping_req_o));

  // R2
  ent_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_req_o && !ent_ack_i && !dup_mismatch |=> ent_req_o);

  // R4
  ping_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ping_req_o != '0) && ((ping_req_o & ping_ack_i) == '0) && !timeout_evt && !dup_mismatch
    |=> $stable(ping_req_o));

  // R7
  fail_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(fail_o) == 1) && !is_err |-> ($past(ping_req_o) == fail_o));

endmodule

bind ping_timer ping_timer_chk #(.N_TARGETS(N_TARGETS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ent_req_o(ent_req_o), .ent_ack_i(ent_ack_i),
  .ping_req_o(ping_req_o), .ping_ack_i(ping_ack_i), .fail_o(fail_o),
  .is_err(is_err), .dup_mismatch(dup_mismatch), .timeout_evt(timeout_evt)
);

// File: tb/sim_ping_timer.sv
module sim_ping_timer;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 6;
  localparam int LW  = 16;
  localparam int CW  = 16;
  localparam int K   = 4;
  localparam int WATCHDOG = 150000;

  localparam int M_IDLE = 0, M_RESEED = 1, M_WAIT = 2, M_PING = 3, M_ERR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] timeout = 16'd6;
  logic          ent_req, ent_ack = 1'b0;
  logic [LW-1:0] ent_data = '0;
  logic [N-1:0]  ping_ack = '0;
  logic [N-1:0]  ping_req, fail;

  ping_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .timeout_i(timeout),
    .ent_req_o(ent_req), .ent_ack_i(ent_ack), .ent_data_i(ent_data),
    .ping_ack_i(ping_ack), .ping_req_o(ping_req), .fail_o(fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_lfsr, m_cnt, m_pcnt;
  bit [N-1:0] m_fail;
  bit inj = 1'b0;

  function automatic int m_step(input int x);
    return (x >> 1) ^ (((x & 1) != 0) ? 'hB400 : 0);
  endfunction
  function automatic int m_tgt(input int x);
    return ((x >> 8) & 255) % N;
  endfunction
  function automatic int m_wait(input int x);
    return 2 + (x & 15);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = M_RESEED; m_lfsr = 1; m_cnt = 0; m_pcnt = 0; m_fail = '0;
    end else if (m_st == M_ERR || inj) begin
      m_st = M_ERR;
    end else begin
      m_fail = '0;
      case (m_st)
        M_RESEED: if (ent_ack) begin
          m_lfsr = (ent_data == 0) ? 1 : int'(ent_data);
          m_pcnt = 0;
          m_st = M_IDLE;
        end
        M_IDLE: if (en) m_st = M_WAIT;
        M_WAIT: begin
          if (!en) begin m_st = M_IDLE; m_cnt = 0; end
          else if (m_cnt == m_wait(m_lfsr)) begin m_st = M_PING; m_cnt = 0; end
          else m_cnt++;
        end
        M_PING: begin
          automatic int t = m_tgt(m_lfsr);
          automatic bit done = 1'b0;
          if (ping_ack[t]) done = 1'b1;
          else if (m_cnt >= int'(timeout)) begin m_fail[t] = 1'b1; done = 1'b1; end
          else m_cnt++;
          if (done) begin
            m_lfsr = m_step(m_lfsr);
            m_cnt = 0;
            if (m_pcnt == K - 1) m_st = M_RESEED;
            else begin m_pcnt++; m_st = M_IDLE; end
          end
        end
        default: ;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  int ping_rises = 0, fail_cycles = 0, ent_rises = 0;
  bit prev_ping = 1'b0, prev_ent = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit [N-1:0] e_ping = (m_st == M_PING) ? (N'(1) << m_tgt(m_lfsr)) : '0;
      automatic bit [N-1:0] e_fail = (m_st == M_ERR) ? '1 : m_fail;
      automatic bit e_ent = (m_st == M_RESEED);
      check(ent_req === e_ent, "R2 R9", {phase, " ent_req"}, ent_req, e_ent);
      check(ping_req === e_ping, "R4 R3 R5", {phase, " ping_req"}, ping_req, e_ping);
      check(fail === e_fail, "R7 R10", {phase, " fail"}, fail, e_fail);
      if (ping_req != 0 && !prev_ping) ping_rises++;
      if (ent_req && !prev_ent) ent_rises++;
      if (fail != 0) fail_cycles++;
      prev_ping = (ping_req != 0);
      prev_ent  = ent_req;
    end else begin
      prev_ping = 1'b0;
      prev_ent  = 1'b0;
    end
  end

  // ---------------- peer responders ----------------
  int ent_delay = 3, ent_wait = 0;
  int ack_delay = 1, hi_cnt = 0;
  bit [N-1:0] resp_mask = '1;
  bit noise_on = 1'b0;
  logic [LW-1:0] next_seed = '0;

  always @(negedge clk) begin
    if (ent_req) begin
      ent_wait++;
      ent_ack  = (ent_wait > ent_delay);
      ent_data = next_seed;
      if (ent_ack) next_seed = LW'($urandom);
    end else begin
      ent_wait = 0;
      ent_ack  = 1'b0;
      ent_data = LW'($urandom);
    end
    if (ping_req != 0) hi_cnt++;
    else hi_cnt = 0;
    ping_ack = ((hi_cnt > ack_delay) ? (ping_req & resp_mask) : '0)
             | (noise_on ? (N'($urandom) & ~ping_req) : '0);
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    inj = 1'b0;
    run(3);
    rst_n = 1'b1;
  endtask

  initial begin
    int pr, fc, er;
    // R1: outputs while reset is held
    run(2);
    check(ent_req === 1'b1, "R1", "reset ent_req", ent_req, 1);
    check(ping_req === '0, "R1", "reset ping_req", ping_req, 0);
    check(fail === '0, "R1", "reset fail", fail, 0);
    rst_n = 1'b1;

    // R2 R8: zero seed, enable low, nothing pinged
    phase = "R2 R8";
    ent_delay = 6;
    next_seed = '0;
    pr = ping_rises;
    run(60);
    check(ping_rises == pr, "R8", "pings while disabled", ping_rises - pr, 0);

    // R6: every peer answers, stray acks on other lines
    phase = "R6 R3 R5";
    en = 1'b1; noise_on = 1'b1; ack_delay = 1; resp_mask = '1; timeout = 16'd6;
    fc = fail_cycles; pr = ping_rises;
    run(500);
    check(fail_cycles == fc, "R6", "fails with all answering", fail_cycles - fc, 0);
    check(ping_rises > pr, "R6", "pings issued", ping_rises - pr, 1);

    // R7: silent peers time out
    phase = "R7";
    noise_on = 1'b0; resp_mask = '0; timeout = 16'd4;
    fc = fail_cycles;
    run(400);
    check(fail_cycles > fc, "R7", "fail pulses seen", fail_cycles - fc, 1);

    // R7: timeout zero, answer delay at the timeout boundary
    phase = "R7 R6 boundary";
    timeout = 16'd0; resp_mask = 6'b101010; ack_delay = 0;
    run(300);
    timeout = 16'd3; ack_delay = 3; noise_on = 1'b1;
    run(300);
    ack_delay = 4;
    run(300);

    // R8: toggling enable
    phase = "R8";
    resp_mask = 6'b010101; ack_delay = 2; timeout = 16'd5;
    for (int i = 0; i < 60; i++) begin
      en = ($urandom % 3) != 0;
      run(1 + ($urandom % 12));
    end
    en = 1'b1;

    // R9: repeated reseeding
    phase = "R9";
    er = ent_rises; ent_delay = 0;
    run(600);
    check(ent_rises - er >= 2, "R9", "reseed requests", ent_rises - er, 2);

    // R10: LFSR copy disagreement
    phase = "R10 lfsr";
    @(negedge clk);
    force u0.lfsr_b = 16'h0000;
    inj = 1'b1;
    @(negedge clk);
    release u0.lfsr_b;
    inj = 1'b0;
    for (int i = 0; i < 20; i++) begin
      check(fail === '1 && ping_req === '0 && ent_req === 1'b0, "R10",
            "lfsr fault latch", {fail, ping_req, ent_req}, {6'h3f, 6'h00, 1'b0});
      run(1);
    end

    // R10: counter copy disagreement after a fresh reset
    do_reset();
    phase = "R10 cnt";
    ent_delay = 2; resp_mask = '1; ack_delay = 1;
    run(80);
    @(negedge clk);
    force u0.cnt_b = 16'hABCD;
    inj = 1'b1;
    @(negedge clk);
    release u0.cnt_b;
    inj = 1'b0;
    for (int i = 0; i < 20; i++) begin
      check(fail === '1 && ping_req === '0 && ent_req === 1'b0, "R10",
            "counter fault latch", {fail, ping_req, ent_req}, {6'h3f, 6'h00, 1'b0});
      run(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule